// File: doc/BRIEF.md
# Memory-Mapped Event Timer Core

This block is the register-facing core of a multi-channel event timer. It keeps a 64-bit main counter that advances on a tick-enable input, a general configuration register, a read-only capability word and an interrupt status word. It also holds the configuration, comparator and route registers for three comparator channels and presents them on output buses. The comparison logic that consumes those registers sits outside this block.

Software reaches the core through a single-cycle request bus. Each request carries an address, a byte length and, for a write, data. Reads and writes of 1, 2, 4 or 8 bytes are accepted when naturally aligned. Narrow reads pick the addressed byte lanes out of the 64-bit register. Narrow writes update only the addressed lanes, and only the bits that register allows to be written. Misaligned or odd-sized requests are rejected.

The counter stops and holds its value while the enable bit is clear. Software may overwrite it while stopped, and counting resumes from the held value. Rewriting the counter while it runs, or switching the core on, pulses a re-evaluation line to every enabled channel.

Top module: `event_timer_core`

## Requirements
- R1: Only address bits 9:0 are decoded, so any address aliases into a 1024-byte window.
- R2: A request is legal when its length is 1, 2, 4 or 8 and its address is a multiple of that length. An illegal read returns all ones, and an illegal write changes no register.
- R3: A legal read returns, on `rdData` in the cycle after the request, the addressed 64-bit register shifted right by 8 × (address bits 2:0) and masked to the length in bytes.
- R4: A legal write of fewer than 8 bytes changes only the addressed byte lanes. The data is taken from the low bytes of `wrData`.
- R5: After reset the main counter (offset 0x0F0) is zero. It increases by one on each clock where `tickEn` is high and configuration bit 0 is set.
- R6: While configuration bit 0 is clear, the counter holds its value and may be written. When bit 0 is set again, counting resumes from the held or written value.
- R7: The configuration register (offset 0x010) resets to zero and has only bits 1:0 writable. Bit 0 drives `globalEn` and bit 1 drives `legacyRoute`.
- R8: The capability register (offset 0x000) is read-only. Its fields are: bits 7:0 revision 1, bits 12:8 channel count minus one, bit 13 set (64-bit counter), bit 15 set (legacy routing capable), bits 31:16 vendor 0x8086, and bits 63:32 the tick period in femtoseconds.
- R9: Channel n has its configuration at 0x100+0x20n (bits 15:1 writable, reset 0, bit 2 = channel enable), its comparator at 0x108+0x20n (reset all ones) and its route at 0x110+0x20n (reset 0). All three appear on the channel output buses.
- R10: Status bit n (offset 0x020) is set by a high `chanIrq[n]` and cleared by writing a one to it. A set in the same cycle wins over the clear.
- R11: `reEval[n]` pulses for one cycle after a counter write made while bit 0 is set, or after a write that sets bit 0 from clear, when channel n's enable bit was set before that write.
- R12: Reads of unmapped offsets return zero, and writes to unmapped offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable |
| req | input | 1 | Request valid for one cycle |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address |
| len | input | 4 | Access length in bytes |
| wrData | input | 64 | Write data, low-aligned |
| chanIrq | input | 3 | Per-channel interrupt set lines |
| rdData | output | 64 | Read result, valid the cycle after a read |
| globalEn | output | 1 | Configuration bit 0 |
| legacyRoute | output | 1 | Configuration bit 1 |
| mainCount | output | 64 | Main counter value |
| chanCfg | output | 192 | Channel configuration registers, channel 0 in the low bits |
| chanCmp | output | 192 | Channel comparator registers |
| chanRoute | output | 192 | Channel route registers |
| reEval | output | 3 | Per-channel re-evaluation pulse |

## Verification
The hardest case to reach from the ports is how narrow accesses combine with legality and masking. Every offset within a quadword meets every length from 1 to 8. The stimulus therefore sweeps all 64 offset/length pairs, once as reads of a known full-width pattern and once as writes over it, and the expected lanes are worked out with shifts and masks. The hold/resume behaviour of the counter is reached with a counted burst of `tickEn` cycles on each side of a disable, an overwrite and a re-enable.

// File: rtl/etm_pkg.sv
package etm_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_CAP, SEL_CFG, SEL_STAT, SEL_CNT,
    SEL_CHCFG, SEL_CHCMP, SEL_CHROUTE
  } regSelE;

  typedef struct packed {
    logic        doWrite;
    logic        doRead;
    logic        bad;
    regSelE      sel;
    logic [4:0]  chan;
    logic [5:0]  shamt;
    logic [63:0] lenMask;
    logic [63:0] laneMask;
  } strobeT;
endpackage

// File: rtl/etm_ctrl.sv
module etm_ctrl
  import etm_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 16
) (
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        len,
  output strobeT            stb
);
  localparam int WIN_BITS = 10;

  logic [2:0]  off;
  logic [6:0]  qw;
  logic [6:0]  rel;
  logic        legal;
  logic [63:0] lenMask;
  regSelE      sel;
  logic [4:0]  chan;
  logic        unusedAddrBits;

  assign unusedAddrBits = ^addr[ADDR_W-1:WIN_BITS];
  assign off = addr[2:0];
  assign qw  = addr[WIN_BITS-1:3];
  assign rel = qw - 7'd32;

  always_comb begin
    unique case (len)
      4'd1:    legal = 1'b1;
      4'd2:    legal = (off[0] == 1'b0);
      4'd4:    legal = (off[1:0] == 2'b00);
      4'd8:    legal = (off == 3'b000);
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    unique case (len)
      4'd1:    lenMask = 64'h0000_0000_0000_00FF;
      4'd2:    lenMask = 64'h0000_0000_0000_FFFF;
      4'd4:    lenMask = 64'h0000_0000_FFFF_FFFF;
      default: lenMask = '1;
    endcase
  end

  always_comb begin
    sel  = SEL_NONE;
    chan = '0;
    if (qw == 7'd0)       sel = SEL_CAP;
    else if (qw == 7'd2)  sel = SEL_CFG;
    else if (qw == 7'd4)  sel = SEL_STAT;
    else if (qw == 7'd30) sel = SEL_CNT;
    else if (qw >= 7'd32 && int'(rel[6:2]) < NCH) begin
      chan = rel[6:2];
      unique case (rel[1:0])
        2'd0:    sel = SEL_CHCFG;
        2'd1:    sel = SEL_CHCMP;
        2'd2:    sel = SEL_CHROUTE;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    stb.doWrite  = req && wrEn && legal;
    stb.doRead   = req && !wrEn;
    stb.bad      = !legal;
    stb.sel      = sel;
    stb.chan     = chan;
    stb.shamt    = {off, 3'b000};
    stb.lenMask  = lenMask;
    stb.laneMask = lenMask << {off, 3'b000};
  end
endmodule

// File: rtl/etm_data.sv
module etm_data
  import etm_pkg::*;
#(
  parameter int          NCH     = 3,
  parameter logic [31:0] TICK_FS = 32'd16_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [NCH-1:0]    chanIrq,
  input  logic [63:0]       wrData,
  input  strobeT            stb,
  output logic [63:0]       rdData,
  output logic              globalEn,
  output logic              legacyRoute,
  output logic [63:0]       mainCount,
  output logic [NCH*64-1:0] chanCfg,
  output logic [NCH*64-1:0] chanCmp,
  output logic [NCH*64-1:0] chanRoute,
  output logic [NCH-1:0]    reEval
);
  localparam logic [63:0] CH_CFG_WMASK = 64'h0000_0000_0000_FFFE;
  localparam int          CH_EN_BIT    = 2;
  localparam logic [4:0]  NUM_FIELD    = 5'(NCH - 1);
  localparam logic [63:0] CAP_WORD = {TICK_FS, 16'h8086, 1'b1, 1'b0, 1'b1,
                                      NUM_FIELD, 8'h01};

  logic [1:0]     cfgReg;
  logic [63:0]    count;
  logic [NCH-1:0] stat;
  logic [63:0]    chCfg   [NCH];
  logic [63:0]    chCmp   [NCH];
  logic [63:0]    chRoute [NCH];
  logic [63:0]    curQ;
  logic [63:0]    shifted;
  logic [63:0]    merged;
  logic           cntWr;
  logic           cfgWr;
  logic           enRise;
  logic           kick;

  assign shifted = wrData << stb.shamt;
  assign merged  = (shifted & stb.laneMask) | (curQ & ~stb.laneMask);
  assign cntWr   = stb.doWrite && stb.sel == SEL_CNT;
  assign cfgWr   = stb.doWrite && stb.sel == SEL_CFG;
  assign enRise  = cfgWr && !cfgReg[0] && merged[0];
  assign kick    = (cntWr && cfgReg[0]) || enRise;

  always_comb begin
    curQ = '0;
    unique case (stb.sel)
      SEL_CAP:  curQ = CAP_WORD;
      SEL_CFG:  curQ = {62'd0, cfgReg};
      SEL_STAT: curQ = {{(64-NCH){1'b0}}, stat};
      SEL_CNT:  curQ = count;
      SEL_CHCFG, SEL_CHCMP, SEL_CHROUTE: begin
        for (int n = 0; n < NCH; n++) begin
          if (stb.chan == 5'(n)) begin
            if (stb.sel == SEL_CHCFG)      curQ = chCfg[n];
            else if (stb.sel == SEL_CHCMP) curQ = chCmp[n];
            else                           curQ = chRoute[n];
          end
        end
      end
      default:  curQ = '0;
    endcase
  end

  // general configuration, counter, status, read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
      count  <= '0;
      stat   <= '0;
      rdData <= '0;
    end else begin
      if (cfgWr) cfgReg <= merged[1:0];
      if (cntWr) count <= merged;
      else if (cfgReg[0] && tickEn) count <= count + 64'd1;
      if (stb.doWrite && stb.sel == SEL_STAT)
        stat <= (stat & ~(shifted[NCH-1:0] & stb.laneMask[NCH-1:0])) | chanIrq;
      else
        stat <= stat | chanIrq;
      if (stb.doRead)
        rdData <= stb.bad ? '1 : ((curQ >> stb.shamt) & stb.lenMask);
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    logic hit;
    assign hit = stb.doWrite && stb.chan == 5'(n);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chCfg[n]   <= '0;
        chCmp[n]   <= '1;
        chRoute[n] <= '0;
        reEval[n]  <= 1'b0;
      end else begin
        if (hit && stb.sel == SEL_CHCFG)
          chCfg[n] <= (merged & CH_CFG_WMASK) | (chCfg[n] & ~CH_CFG_WMASK);
        if (hit && stb.sel == SEL_CHCMP)   chCmp[n]   <= merged;
        if (hit && stb.sel == SEL_CHROUTE) chRoute[n] <= merged;
        reEval[n] <= kick && chCfg[n][CH_EN_BIT];
      end
    end

    assign chanCfg[n*64 +: 64]   = chCfg[n];
    assign chanCmp[n*64 +: 64]   = chCmp[n];
    assign chanRoute[n*64 +: 64] = chRoute[n];
  end

  assign globalEn    = cfgReg[0];
  assign legacyRoute = cfgReg[1];
  assign mainCount   = count;

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg[0] && tickEn && !cntWr) |=> (count == $past(count) + 64'd1));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgReg[0] && !cntWr) |=> $stable(count));

  assert_bad_read_ones_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doRead && stb.bad) |=> (rdData == '1));

  assert_bad_write_cfg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bad) |=> $stable(cfgReg));

  assert_reeval_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|reEval) |-> $past(stb.doWrite));
endmodule

// File: rtl/event_timer_core.sv
module event_timer_core
  import etm_pkg::*;
#(
  parameter int          NCH     = 3,
  parameter int          ADDR_W  = 16,
  parameter logic [31:0] TICK_FS = 32'd16_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        len,
  input  logic [63:0]       wrData,
  input  logic [NCH-1:0]    chanIrq,
  output logic [63:0]       rdData,
  output logic              globalEn,
  output logic              legacyRoute,
  output logic [63:0]       mainCount,
  output logic [NCH*64-1:0] chanCfg,
  output logic [NCH*64-1:0] chanCmp,
  output logic [NCH*64-1:0] chanRoute,
  output logic [NCH-1:0]    reEval
);
  strobeT stb;

  etm_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_ctrl (
    .req(req), .wrEn(wrEn), .addr(addr), .len(len), .stb(stb)
  );

  etm_data #(.NCH(NCH), .TICK_FS(TICK_FS)) u_data (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .chanIrq(chanIrq),
    .wrData(wrData), .stb(stb), .rdData(rdData), .globalEn(globalEn),
    .legacyRoute(legacyRoute), .mainCount(mainCount), .chanCfg(chanCfg),
    .chanCmp(chanCmp), .chanRoute(chanRoute), .reEval(reEval)
  );
endmodule

// File: tb/tb_event_timer_core.sv
`timescale 1ns/1ps
module tb_event_timer_core;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rstN;
  logic              tickEn;
  logic              req;
  logic              wrEn;
  logic [15:0]       addr;
  logic [3:0]        len;
  logic [63:0]       wrData;
  logic [NCH-1:0]    chanIrq;
  logic [63:0]       rdData;
  logic              globalEn;
  logic              legacyRoute;
  logic [63:0]       mainCount;
  logic [NCH*64-1:0] chanCfg;
  logic [NCH*64-1:0] chanCmp;
  logic [NCH*64-1:0] chanRoute;
  logic [NCH-1:0]    reEval;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  event_timer_core dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .req(req), .wrEn(wrEn),
    .addr(addr), .len(len), .wrData(wrData), .chanIrq(chanIrq),
    .rdData(rdData), .globalEn(globalEn), .legacyRoute(legacyRoute),
    .mainCount(mainCount), .chanCfg(chanCfg), .chanCmp(chanCmp),
    .chanRoute(chanRoute), .reEval(reEval)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [3:0] l, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; wrEn = 1'b1; addr = a; len = l; wrData = d;
    @(negedge clk);
    req = 1'b0; wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, input logic [3:0] l, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; wrEn = 1'b0; addr = a; len = l;
    @(negedge clk);
    req = 1'b0;
    d = rdData;
  endtask

  task automatic ticks(input int k);
    tickEn = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  function automatic logic [63:0] maskOf(input int l);
    return (l == 8) ? '1 : ((64'd1 << (8 * l)) - 64'd1);
  endfunction

  function automatic bit legalOf(input int l, input int o);
    return (l == 1 || l == 2 || l == 4 || l == 8) && (o % l == 0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] pat;
    logic [63:0] wpat;
    logic [63:0] capExp;
    rstN = 1'b0; tickEn = 1'b0; req = 1'b0; wrEn = 1'b0;
    addr = '0; len = 4'd8; wrData = '0; chanIrq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // reset state
    capExp = (64'd16_000_000 << 32) | (64'h8086 << 16) | (64'd1 << 15) |
             (64'd1 << 13) | (64'd2 << 8) | 64'd1;
    busRead(16'h000, 4'd8, v); chk("R8 capability", v, capExp);
    busRead(16'h010, 4'd8, v); chk("R7 cfg reset", v, 64'd0);
    busRead(16'h0F0, 4'd8, v); chk("R5 counter reset", v, 64'd0);
    busRead(16'h020, 4'd8, v); chk("R10 status reset", v, 64'd0);
    for (int n = 0; n < NCH; n++) begin
      busRead(16'(16'h100 + 32 * n), 4'd8, v); chk("R9 chcfg reset", v, 64'd0);
      busRead(16'(16'h108 + 32 * n), 4'd8, v); chk("R9 chcmp reset", v, '1);
      busRead(16'(16'h110 + 32 * n), 4'd8, v); chk("R9 chroute reset", v, 64'd0);
    end
    chk("R7 globalEn reset", {63'd0, globalEn}, 64'd0);

    // R8 read-only
    busWrite(16'h000, 4'd8, 64'd0);
    busRead(16'h000, 4'd8, v); chk("R8 capability not writable", v, capExp);

    // R3/R2 read sweep over every length and offset
    pat = 64'h0123_4567_89AB_CDEF;
    busWrite(16'h108, 4'd8, pat);
    chk("R9 cmp output bus", chanCmp[63:0], pat);
    for (int l = 1; l <= 8; l++) begin
      for (int o = 0; o < 8; o++) begin
        busRead(16'(16'h108 + o), 4'(l), v);
        if (legalOf(l, o)) chk("R3 narrow read", v, (pat >> (8 * o)) & maskOf(l));
        else               chk("R2 illegal read", v, '1);
      end
    end

    // R4/R2 write sweep on channel 0 route
    wpat = 64'hFEDC_BA98_7654_3210;
    for (int l = 1; l <= 8; l++) begin
      for (int o = 0; o < 8; o++) begin
        logic [63:0] lane;
        busWrite(16'h110, 4'd8, pat);
        busWrite(16'(16'h110 + o), 4'(l), wpat);
        busRead(16'h110, 4'd8, v);
        lane = maskOf(l) << (8 * o);
        if (legalOf(l, o)) chk("R4 lane merge", v, (pat & ~lane) | ((wpat << (8 * o)) & lane));
        else               chk("R2 illegal write dropped", v, pat);
      end
    end

    // R1 aliasing
    busRead(16'h0508, 4'd8, v); chk("R1 alias read cmp0", v, pat);
    busWrite(16'hFD10, 4'd8, 64'h55);
    busRead(16'h0110, 4'd8, v); chk("R1 alias write route0", v, 64'h55);

    // R12 unmapped
    busWrite(16'h300, 4'd8, '1);
    busRead(16'h300, 4'd8, v); chk("R12 unmapped read zero", v, 64'd0);
    busRead(16'h118, 4'd8, v); chk("R12 hole in channel block", v, 64'd0);
    busRead(16'h170, 4'd8, v); chk("R12 beyond last channel", v, 64'd0);

    // R9 channel cfg writable mask
    busWrite(16'h140, 4'd8, '1);
    busRead(16'h140, 4'd8, v); chk("R9 chcfg mask", v, 64'hFFFE);
    busWrite(16'h140, 4'd8, 64'd0);

    // R7 cfg mask and outputs
    busWrite(16'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE);
    busRead(16'h010, 4'd8, v); chk("R7 cfg mask", v, 64'd2);
    chk("R7 legacyRoute out", {63'd0, legacyRoute}, 64'd1);
    chk("R7 globalEn stays 0", {63'd0, globalEn}, 64'd0);
    busWrite(16'h010, 4'd8, 64'd0);

    // R10 status
    @(negedge clk); chanIrq = 3'b010; @(negedge clk); chanIrq = '0;
    busRead(16'h020, 4'd8, v); chk("R10 status set", v, 64'd2);
    busWrite(16'h020, 4'd1, 64'h02);
    busRead(16'h020, 4'd8, v); chk("R10 status w1c", v, 64'd0);
    @(negedge clk); chanIrq = 3'b101; @(negedge clk); chanIrq = '0;
    busWrite(16'h021, 4'd1, 64'hFF);
    busRead(16'h020, 4'd8, v); chk("R10 clear other lane keeps", v, 64'd5);
    busWrite(16'h020, 4'd8, 64'h7);

    // R5/R6/R11 counter control
    busWrite(16'h100, 4'd8, 64'h4);
    busWrite(16'h010, 4'd8, 64'd1);
    chk("R11 reEval on enable", {61'd0, reEval}, 64'd1);
    @(negedge clk);
    chk("R11 reEval one cycle", {61'd0, reEval}, 64'd0);
    ticks(10);
    busRead(16'h0F0, 4'd8, v); chk("R5 count ten ticks", v, 64'd10);
    busWrite(16'h010, 4'd8, 64'd0);
    ticks(7);
    busRead(16'h0F0, 4'd8, v); chk("R6 hold while disabled", v, 64'd10);
    busWrite(16'h0F0, 4'd8, 64'd1000);
    chk("R11 no reEval when disabled", {61'd0, reEval}, 64'd0);
    busRead(16'h0F0, 4'd8, v); chk("R6 write while stopped", v, 64'd1000);
    busWrite(16'h010, 4'd8, 64'd1);
    ticks(5);
    busRead(16'h0F0, 4'd8, v); chk("R6 resume from written", v, 64'd1005);
    chk("R5 mainCount output", mainCount, 64'd1005);
    busWrite(16'h0F0, 4'd8, 64'd50);
    chk("R11 reEval on running write", {61'd0, reEval}, 64'd1);
    busRead(16'h0F0, 4'd8, v); chk("R11 running write value", v, 64'd50);
    busWrite(16'h0F4, 4'd4, 64'd1);
    busRead(16'h0F0, 4'd8, v); chk("R4 counter upper half", v, (64'd1 << 32) | 64'd50);
    busWrite(16'h0F0, 4'd3, 64'd0);
    busRead(16'h0F0, 4'd8, v); chk("R2 length three dropped", v, (64'd1 << 32) | 64'd50);
    busWrite(16'h010, 4'd8, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule